// File: doc/BRIEF.md
# Command-Addressed GPIO Register Bank

This block is an eight-bit general-purpose I/O port that sits behind a byte-level serial slave. The slave decodes a command code and, on its acknowledge strobe, hands the block either a write (command plus data byte) or a read request (command only). Four registers control the port: a sampled input register, an output latch, a polarity-inversion mask and a direction mask. Pads are modelled as sampled input levels plus a per-pin pull-low enable, because the outputs are open drain.

Three further command codes load a byte fetched from memory straight into the output, polarity or direction register. A fourth captures the input register into a snapshot byte that the memory path can write away. An active-low reset pin clears all port registers to their defaults, but only after it has been held low for more than a parameterised number of clock cycles. The registers then stay cleared until the pin returns high.

Top module: `gpio_bank`

## Requirements
- R1: After `rstN` is released, the output register reads 8'h00, polarity reads 8'hF0, direction reads 8'h00, the input register reads 8'h00, `rdData` and `snapData` are 8'h00 and every pin is pulled low.
- R2: An acknowledge with `wrEn`=1 and command 8'h08, 8'h09 or 8'h0A loads `wrData` into the output, polarity or direction register respectively, at that clock edge.
- R3: An acknowledge with `wrEn`=0 updates `rdData` at that edge with the register chosen by the command (8'h07 input, 8'h08 output, 8'h09 polarity, 8'h0A direction; any other code gives 8'h00). `rdData` holds its value between read acknowledges.
- R4: The input register is resampled on every clock as pad level XOR (polarity AND direction). Pins configured as outputs therefore report their raw pad level.
- R5: A write to command 8'h07, or any command presented without the acknowledge strobe, leaves all registers unchanged.
- R6: `padPullLow[i]` is 1 exactly when direction bit i is 0 and output bit i is 0.
- R7: A direction bit of 1 makes the pin an input, which is never pulled low whatever its output bit holds.
- R8: An acknowledge with command 8'h0F, 8'h10 or 8'h11 loads `memData` into the output, polarity or direction register respectively, whatever the value of `wrEn`.
- R9: An acknowledge with command 8'h12 copies the input register into `snapData`. `snapData` keeps that value until the next such acknowledge.
- R10: `extRstN` must be low for MIN_RST_CYC+1 consecutive clock edges to clear the registers. A shorter low pulse has no effect, and the count starts again from zero whenever the pin is high.
- R11: While the reset pin remains low after qualification, the registers stay at their defaults and acknowledged writes or loads are ignored. Normal operation resumes once the pin is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low power-on reset, asynchronous |
| extRstN | input | 1 | Active-low external port reset pin, synchronous to clk |
| ackStb | input | 1 | One-cycle strobe at the slave acknowledge |
| wrEn | input | 1 | 1 = write transfer, 0 = read transfer |
| cmdCode | input | 8 | Command code of the current transfer |
| wrData | input | 8 | Data byte of a write transfer |
| memData | input | 8 | Byte fetched from memory for the load commands |
| padIn | input | 8 | Sampled pad levels |
| rdData | output | 8 | Byte returned for a read transfer |
| snapData | output | 8 | Input-register snapshot for a transfer into memory |
| padPullLow | output | 8 | Per-pin open-drain pull-low enable |

## Verification
A corrupted output or direction register shows up on `padPullLow` one clock after the acknowledge that caused it. A corrupted polarity mask stays hidden until a pin is switched to input and the input register is read back. That read needs one cycle for resampling and one for the acknowledge. A reset-width counter that is off by one clears the port one edge early or one edge late, so the bench probes both MIN_RST_CYC and MIN_RST_CYC+1 low cycles, plus a pulse interrupted by a single high cycle.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  // Command codes; values are fixed by the upstream slave's decode.
  localparam logic [7:0] CMD_RD_IN   = 8'h07;
  localparam logic [7:0] CMD_OUT     = 8'h08;
  localparam logic [7:0] CMD_POL     = 8'h09;
  localparam logic [7:0] CMD_DIR     = 8'h0A;
  localparam logic [7:0] CMD_MEM_OUT = 8'h0F;
  localparam logic [7:0] CMD_MEM_POL = 8'h10;
  localparam logic [7:0] CMD_MEM_DIR = 8'h11;
  localparam logic [7:0] CMD_SNAP    = 8'h12;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_IN,
    SEL_OUT,
    SEL_POL,
    SEL_DIR
  } rdSel_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic   clrAll;
    logic   ldOut;
    logic   ldPol;
    logic   ldDir;
    logic   fromMem;
    logic   rdLatch;
    rdSel_e rdSel;
    logic   snap;
  } ctrlStb_t;

endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int MIN_RST_CYC = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       extRstN,
  input  logic       ackStb,
  input  logic       wrEn,
  input  logic [7:0] cmdCode,
  output ctrlStb_t   stb
);

  localparam int CNT_W = $clog2(MIN_RST_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_RST_CYC);

  logic [CNT_W-1:0] lowCnt;
  logic             heldClr;
  logic             accept;

  // Low-width qualification: counts consecutive low edges, saturating.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                lowCnt <= '0;
    else if (extRstN)         lowCnt <= '0;
    else if (lowCnt != CNT_MAX) lowCnt <= lowCnt + 1'b1;
  end

  assign heldClr = !extRstN && (lowCnt == CNT_MAX);
  assign accept  = ackStb && !heldClr;

  always_comb begin
    stb         = '0;
    stb.rdSel   = SEL_NONE;
    stb.clrAll  = heldClr;
    stb.rdLatch = ackStb && !wrEn;
    unique case (cmdCode)
      CMD_RD_IN:   stb.rdSel = SEL_IN;
      CMD_OUT: begin
        stb.rdSel = SEL_OUT;
        stb.ldOut = accept && wrEn;
      end
      CMD_POL: begin
        stb.rdSel = SEL_POL;
        stb.ldPol = accept && wrEn;
      end
      CMD_DIR: begin
        stb.rdSel = SEL_DIR;
        stb.ldDir = accept && wrEn;
      end
      CMD_MEM_OUT: begin
        stb.fromMem = 1'b1;
        stb.ldOut   = accept;
      end
      CMD_MEM_POL: begin
        stb.fromMem = 1'b1;
        stb.ldPol   = accept;
      end
      CMD_MEM_DIR: begin
        stb.fromMem = 1'b1;
        stb.ldDir   = accept;
      end
      CMD_SNAP:    stb.snap = ackStb;
      default:     ;
    endcase
  end

endmodule

// File: rtl/gpio_bank_dp.sv
module gpio_bank_dp
  import gpio_bank_pkg::*;
#(
  parameter int               WIDTH   = 8,
  parameter logic [WIDTH-1:0] POL_RST = 8'hF0
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStb_t         stb,
  input  logic [WIDTH-1:0] wrData,
  input  logic [WIDTH-1:0] memData,
  input  logic [WIDTH-1:0] padIn,
  output logic [WIDTH-1:0] rdData,
  output logic [WIDTH-1:0] snapData,
  output logic [WIDTH-1:0] padPullLow
);

  logic [WIDTH-1:0] outReg, polReg, dirReg, inReg;
  logic [WIDTH-1:0] loadVal, rdMux;

  assign loadVal = stb.fromMem ? memData : wrData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outReg <= '0;
      polReg <= POL_RST;
      dirReg <= '0;
      inReg  <= '0;
    end else if (stb.clrAll) begin
      outReg <= '0;
      polReg <= POL_RST;
      dirReg <= '0;
      inReg  <= '0;
    end else begin
      if (stb.ldOut) outReg <= loadVal;
      if (stb.ldPol) polReg <= loadVal;
      if (stb.ldDir) dirReg <= loadVal;
      inReg <= padIn ^ (polReg & dirReg);
    end
  end

  always_comb begin
    unique case (stb.rdSel)
      SEL_IN:  rdMux = inReg;
      SEL_OUT: rdMux = outReg;
      SEL_POL: rdMux = polReg;
      SEL_DIR: rdMux = dirReg;
      default: rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData   <= '0;
      snapData <= '0;
    end else begin
      if (stb.rdLatch) rdData   <= rdMux;
      if (stb.snap)    snapData <= inReg;
    end
  end

  // Open drain: pulled low only as a driven output holding zero.
  assign padPullLow = ~dirReg & ~outReg;

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int               WIDTH       = 8,
  parameter int               MIN_RST_CYC = 16,
  parameter logic [WIDTH-1:0] POL_RST     = 8'hF0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             extRstN,
  input  logic             ackStb,
  input  logic             wrEn,
  input  logic [7:0]       cmdCode,
  input  logic [WIDTH-1:0] wrData,
  input  logic [WIDTH-1:0] memData,
  input  logic [WIDTH-1:0] padIn,
  output logic [WIDTH-1:0] rdData,
  output logic [WIDTH-1:0] snapData,
  output logic [WIDTH-1:0] padPullLow
);

  ctrlStb_t stb;

  gpio_bank_ctrl #(.MIN_RST_CYC(MIN_RST_CYC)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .extRstN (extRstN),
    .ackStb  (ackStb),
    .wrEn    (wrEn),
    .cmdCode (cmdCode),
    .stb     (stb)
  );

  gpio_bank_dp #(.WIDTH(WIDTH), .POL_RST(POL_RST)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .wrData     (wrData),
    .memData    (memData),
    .padIn      (padIn),
    .rdData     (rdData),
    .snapData   (snapData),
    .padPullLow (padPullLow)
  );

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int WIDTH       = 8,
  parameter int MIN_RST_CYC = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             extRstN,
  input logic             ackStb,
  input logic             wrEn,
  input logic [7:0]       cmdCode,
  input logic [WIDTH-1:0] wrData,
  input logic [WIDTH-1:0] rdData,
  input logic [WIDTH-1:0] snapData,
  input logic [WIDTH-1:0] padPullLow
);

  int lowSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        lowSeen <= 0;
    else if (extRstN)                 lowSeen <= 0;
    else if (lowSeen < MIN_RST_CYC)   lowSeen <= lowSeen + 1;
  end

  // R3: read data only moves on an acknowledge
  p_rd_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !ackStb |=> $stable(rdData));

  // R5: a write aimed at the input register changes no pin drive
  p_in_ro_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ackStb && wrEn && cmdCode == 8'h07 && extRstN) |=> $stable(padPullLow));

  // R7: pins just made inputs are never pulled low
  p_dir_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ackStb && wrEn && cmdCode == 8'h0A && extRstN)
      |=> ((padPullLow & $past(wrData)) == '0));

  // R9: snapshot only moves on its own command
  p_snap_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(ackStb && cmdCode == 8'h12) |=> $stable(snapData));

  // R10: a qualified low pin returns every pin to a driven zero
  p_clr_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!extRstN && lowSeen == MIN_RST_CYC) |=> (padPullLow == '1));

endmodule

bind gpio_bank gpio_bank_chk #(.WIDTH(WIDTH), .MIN_RST_CYC(MIN_RST_CYC)) u_chk (.*);

// File: tb/tb_gpio_bank.sv
module tb_gpio_bank;

  localparam int CLK_PERIOD = 10;
  localparam int MIN_RST    = 5;
  localparam int NVEC       = 19;

  typedef struct packed {
    logic       wr;
    logic [7:0] cmd;
    logic [7:0] wdat;
    logic [7:0] mdat;
    logic [7:0] pad;
    logic [7:0] expRd;
    logic [7:0] expPull;
  } vec_t;

  // Walked from the reset state; expected values from the requirements.
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 8'h07, 8'h00, 8'h00, 8'hA5, 8'hA5, 8'hFF}, // R4 all outputs: raw pad
    '{1'b1, 8'h0A, 8'h0F, 8'h00, 8'hA5, 8'hA5, 8'hF0}, // R2 dir, R6
    '{1'b0, 8'h07, 8'h00, 8'h00, 8'hA5, 8'hA5, 8'hF0}, // R4 pol F0 & dir 0F = 0
    '{1'b1, 8'h09, 8'h3C, 8'h00, 8'hA5, 8'hA5, 8'hF0}, // R2 pol, R3 hold
    '{1'b0, 8'h07, 8'h00, 8'h00, 8'hA5, 8'hA9, 8'hF0}, // R4 inverted 0C
    '{1'b1, 8'h08, 8'h55, 8'h00, 8'hA5, 8'hA9, 8'hA0}, // R2 out, R7
    '{1'b0, 8'h08, 8'h00, 8'h00, 8'hA5, 8'h55, 8'hA0}, // R3
    '{1'b0, 8'h09, 8'h00, 8'h00, 8'hA5, 8'h3C, 8'hA0}, // R3
    '{1'b0, 8'h0A, 8'h00, 8'h00, 8'hA5, 8'h0F, 8'hA0}, // R3
    '{1'b1, 8'h07, 8'hFF, 8'h00, 8'hA5, 8'h0F, 8'hA0}, // R5 ignored
    '{1'b0, 8'h07, 8'h00, 8'h00, 8'h00, 8'h0C, 8'hA0}, // R4
    '{1'b1, 8'h0F, 8'hEE, 8'h81, 8'h00, 8'h0C, 8'h70}, // R8 out
    '{1'b0, 8'h08, 8'h00, 8'h00, 8'h00, 8'h81, 8'h70}, // R8 readback
    '{1'b1, 8'h10, 8'hEE, 8'h00, 8'h00, 8'h81, 8'h70}, // R8 pol
    '{1'b1, 8'h11, 8'hEE, 8'hF0, 8'h00, 8'h81, 8'h0E}, // R8 dir, R7
    '{1'b0, 8'h09, 8'h00, 8'h00, 8'h00, 8'h00, 8'h0E}, // R8 readback
    '{1'b0, 8'h0A, 8'h00, 8'h00, 8'h00, 8'hF0, 8'h0E}, // R8 readback
    '{1'b0, 8'h07, 8'h00, 8'h00, 8'h5A, 8'h5A, 8'h0E}, // R4 no inversion
    '{1'b0, 8'h0D, 8'h00, 8'h00, 8'h5A, 8'h00, 8'h0E}  // R3 unknown code
  };

  logic       clk = 1'b0;
  logic       rstN, extRstN, ackStb, wrEn;
  logic [7:0] cmdCode, wrData, memData, padIn;
  logic [7:0] rdData, snapData, padPullLow;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  gpio_bank #(.WIDTH(8), .MIN_RST_CYC(MIN_RST), .POL_RST(8'hF0)) dut (
    .clk(clk), .rstN(rstN), .extRstN(extRstN), .ackStb(ackStb), .wrEn(wrEn),
    .cmdCode(cmdCode), .wrData(wrData), .memData(memData), .padIn(padIn),
    .rdData(rdData), .snapData(snapData), .padPullLow(padPullLow)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Called at a negedge; returns at the negedge after the acknowledge edge.
  task automatic access(input logic wr, input logic [7:0] cmd,
                        input logic [7:0] wd, input logic [7:0] md);
    wrEn = wr; cmdCode = cmd; wrData = wd; memData = md; ackStb = 1'b1;
    @(negedge clk);
    ackStb = 1'b0;
  endtask

  task automatic readReg(input string req, input logic [7:0] cmd, input logic [7:0] exp);
    access(1'b0, cmd, 8'h00, 8'h00);
    check(req, rdData, exp);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    rstN = 1'b0; extRstN = 1'b1; ackStb = 1'b0; wrEn = 1'b0;
    cmdCode = 8'h00; wrData = 8'h00; memData = 8'h00; padIn = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 pull", padPullLow, 8'hFF);
    check("R1 rd", rdData, 8'h00);
    check("R1 snap", snapData, 8'h00);
    readReg("R1 out", 8'h08, 8'h00);
    readReg("R1 pol", 8'h09, 8'hF0);
    readReg("R1 dir", 8'h0A, 8'h00);
    readReg("R1 in", 8'h07, 8'h00);

    // Vector walk
    for (int i = 0; i < NVEC; i++) begin
      padIn = VEC[i].pad;
      @(negedge clk);
      access(VEC[i].wr, VEC[i].cmd, VEC[i].wdat, VEC[i].mdat);
      check($sformatf("R2/R3/R4/R5/R6/R7/R8 vec%0d rd", i), rdData, VEC[i].expRd);
      check($sformatf("R6/R7 vec%0d pull", i), padPullLow, VEC[i].expPull);
    end
    // State now: out 81, pol 00, dir F0

    // R5: command without acknowledge is ignored
    wrEn = 1'b1; cmdCode = 8'h08; wrData = 8'hFF; ackStb = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R5 no ack pull", padPullLow, 8'h0E);
    readReg("R5 no ack out", 8'h08, 8'h81);

    // R9 snapshot
    padIn = 8'h3C;
    @(negedge clk);
    access(1'b1, 8'h12, 8'h00, 8'h00);
    check("R9 snap", snapData, 8'h3C);
    padIn = 8'hFF;
    repeat (3) @(negedge clk);
    check("R9 snap hold", snapData, 8'h3C);

    // R10 short pulse: MIN_RST low edges do not clear
    extRstN = 1'b0;
    repeat (MIN_RST) @(negedge clk);
    extRstN = 1'b1;
    @(negedge clk);
    check("R10 short pull", padPullLow, 8'h0E);
    readReg("R10 short dir", 8'h0A, 8'hF0);

    // R10 restart: interrupted pulse does not accumulate
    extRstN = 1'b0;
    repeat (MIN_RST) @(negedge clk);
    extRstN = 1'b1;
    @(negedge clk);
    extRstN = 1'b0;
    repeat (MIN_RST) @(negedge clk);
    extRstN = 1'b1;
    @(negedge clk);
    readReg("R10 restart dir", 8'h0A, 8'hF0);

    // R10 qualified pulse clears
    extRstN = 1'b0;
    repeat (MIN_RST + 1) @(negedge clk);
    check("R10 clear pull", padPullLow, 8'hFF);

    // R11 writes and loads ignored while held
    access(1'b1, 8'h08, 8'hFF, 8'h00);
    access(1'b1, 8'h11, 8'h00, 8'hFF);
    check("R11 held pull", padPullLow, 8'hFF);
    repeat (2) @(negedge clk);
    extRstN = 1'b1;
    @(negedge clk);
    readReg("R11 out", 8'h08, 8'h00);
    readReg("R11 pol", 8'h09, 8'hF0);
    readReg("R11 dir", 8'h0A, 8'h00);
    // R11 normal operation resumes
    access(1'b1, 8'h08, 8'h01, 8'h00);
    check("R11 resume pull", padPullLow, 8'hFE);

    finish();
  end

endmodule